// File: doc/BRIEF.md
# Pipelined Fixed-Point Attack Classifier Core

This block scores one connection record per cycle with a small fully connected feed-forward network. A record carries six signed features. The first hidden layer has two neurons. The second hidden layer has two neurons. A single output neuron follows. Each neuron adds a bias to the weighted sum of its inputs and then applies a three-segment linear approximation of the logistic curve. A threshold comparator turns the output neuron's value into a one-bit verdict: attack or normal. Verdicts queue in a 16-entry FIFO until a consumer takes them.

All values are signed Q8.8. The 18 weights and 5 biases sit in a register bank written through a simple write port, so the same hardware can serve a retrained model. The two hidden layers are pipeline stages joined by valid/ready handshakes. A full FIFO stalls the pipeline back to the input, so no verdict is lost. For a separate training engine, the block keeps the activations of every neuron for the most recent record that reached the FIFO.

Top module: `mlp_attack_core`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is 1, `pred_valid` is 0, all three tap outputs read zero, and every weight and bias is zero.
- R2: A write with `cfg_we`=1 stores `cfg_data` into the parameter register at `cfg_addr`. Addresses 0..11 are first-layer weights, with address = neuron*6 + feature. Addresses 12..13 are the first-layer biases. Addresses 14..17 are second-layer weights, with address = 14 + neuron*2 + input. Addresses 18..19 are the second-layer biases. Addresses 20..21 are the output weights. Address 22 is the output bias. A write to address 23 or above changes nothing.
- R3: Each neuron forms the Q16.16 sum of bias*256 and all products of input and weight. The sum wraps modulo 2^32. It is shifted right arithmetically by 8 and saturated to the range -32768..32767.
- R4: The activation of a saturated sum s is 0 when s < -1024, 256 when s > 1024, and 128 + (s >>> 3) otherwise.
- R5: The verdict `pred_attack` is 1 exactly when the output neuron's activation is at least 128.
- R6: When a verdict enters the FIFO, `tap_h1` and `tap_h2` take the activations of the first and second hidden layers, with neuron 0 in bits 15:0. At the same time, `tap_out` takes the output activation. All three come from the same record.
- R7: A record accepted at clock edge k enters an empty FIFO at edge k+2 and is visible at the FIFO head after that edge. One record can be accepted on every cycle.
- R8: Verdicts leave the FIFO in acceptance order. While `pred_valid` is 1 and `pred_ready` is 0, the head verdict does not change.
- R9: With `pred_ready` held at 0 from an empty state, exactly 18 records are accepted, then `in_ready` stays 0. All 18 verdicts are delivered later, none lost.
- R10: A verdict is consumed on a cycle where both `pred_valid` and `pred_ready` are 1. `pred_valid` is 0 whenever the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_addr | input | 5 | Parameter register index |
| cfg_data | input | 16 | Q8.8 value to write |
| in_valid | input | 1 | Record present on `in_feat` |
| in_ready | output | 1 | Core accepts a record this cycle |
| in_feat | input | 96 | Six Q8.8 features, feature i at bits 16i+15:16i |
| pred_valid | output | 1 | FIFO head holds a verdict |
| pred_ready | input | 1 | Consumer takes the head verdict |
| pred_attack | output | 1 | Head verdict, 1 = attack |
| tap_h1 | output | 32 | First hidden layer activations of the last queued record |
| tap_h2 | output | 32 | Second hidden layer activations of the last queued record |
| tap_out | output | 16 | Output activation of the last queued record |

## Verification
A record accepted at edge k reaches the FIFO head and the tap outputs two edges later. The single-record checks therefore sample on the falling edge after k, after k+1 and after k+2. They expect `pred_valid` to be low twice, then high with the verdict and taps present. In the streaming runs, each handshake is judged on the falling edge before the rising edge that completes it. Expected verdicts are queued at acceptance and compared at consumption, so any amount of backpressure still lines results up. The full-FIFO run counts acceptances until `in_ready` stays low. It expects the two pipeline stages plus sixteen FIFO entries.

// File: rtl/mlp_pkg.sv
// Shared constants, register map and fixed-point helpers for the classifier core.
// Assumes signed Q8.8 data and a 32-bit Q16.16 accumulator.
package mlp_pkg;
    localparam int DW     = 16;
    localparam int FRAC   = 8;
    localparam int ACC_W  = 32;
    localparam int N_FEAT = 6;
    localparam int N_HID  = 2;

    // Parameter register map (software-visible order matters)
    localparam int L1_W_BASE  = 0;
    localparam int L1_B_BASE  = L1_W_BASE + N_HID * N_FEAT;
    localparam int L2_W_BASE  = L1_B_BASE + N_HID;
    localparam int L2_B_BASE  = L2_W_BASE + N_HID * N_HID;
    localparam int OUT_W_BASE = L2_B_BASE + N_HID;
    localparam int OUT_B      = OUT_W_BASE + N_HID;
    localparam int NUM_REGS   = OUT_B + 1;
    localparam int ADDR_W     = $clog2(NUM_REGS);

    // Activation breakpoints
    localparam int EDGE_Q   = 4 << FRAC;
    localparam int ONE_Q    = 1 << FRAC;
    localparam int HALF_Q   = 1 << (FRAC - 1);
    localparam int SLOPE_SH = 3;

    typedef logic signed [DW-1:0]    q_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    // Scale a Q16.16 sum back to Q8.8 with saturation
    function automatic q_t sat_q(input acc_t a);
        acc_t sh;
        sh = a >>> FRAC;
        if (sh > acc_t'(32767))       return q_t'(16'sh7FFF);
        else if (sh < acc_t'(-32768)) return q_t'(16'sh8000);
        else                          return sh[DW-1:0];
    endfunction

    // Three-segment linear stand-in for the logistic curve
    function automatic q_t pwl_sig(input q_t x);
        q_t slope;
        slope = x >>> SLOPE_SH;
        if (x < q_t'(-EDGE_Q))     return q_t'(0);
        else if (x > q_t'(EDGE_Q)) return q_t'(ONE_Q);
        else                       return q_t'(HALF_Q) + slope;
    endfunction
endpackage

// File: rtl/mlp_param_bank.sv
// Register bank holding every weight and bias of the network.
// Assumes writes arrive only while no record is in flight; out-of-range indices are dropped.
module mlp_param_bank
    import mlp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DW-1:0]          wdata,
    output logic [NUM_REGS*DW-1:0] regs_flat
);
    logic [DW-1:0] bank_q [NUM_REGS];

    // Store an accepted write, clear everything on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) bank_q[i] <= '0;
        end else if (we && (int'(addr) < NUM_REGS)) begin
            bank_q[addr] <= wdata;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_flat[g*DW +: DW] = bank_q[g];
    end
endmodule

// File: rtl/mlp_neuron.sv
// One combinational neuron: bias plus dot product, saturation, then piecewise activation.
// Assumes packed Q8.8 inputs and weights, element i at bits DW*i.
module mlp_neuron
    import mlp_pkg::*;
#(
    parameter int N_IN = 2
) (
    input  logic [N_IN*DW-1:0] x_flat,
    input  logic [N_IN*DW-1:0] w_flat,
    input  q_t                 bias,
    output q_t                 act
);
    acc_t acc;

    // Accumulate the Q16.16 sum, wrapping at the accumulator width
    always_comb begin
        acc = acc_t'(bias) <<< FRAC;
        for (int i = 0; i < N_IN; i++) begin
            acc = acc + acc_t'($signed(x_flat[i*DW +: DW]) * $signed(w_flat[i*DW +: DW]));
        end
    end

    assign act = pwl_sig(sat_q(acc));
endmodule

// File: rtl/mlp_pred_fifo.sv
// Show-ahead FIFO for verdicts; head is valid whenever the FIFO holds an entry.
// Assumes the writer never pushes while full.
module mlp_pred_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] dout
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   count_q;
    logic          do_pop;

    assign valid  = (count_q != '0);
    assign full   = (count_q == (AW+1)'(DEPTH));
    assign dout   = mem_q[rd_q];
    assign do_pop = pop && valid;

    // Write storage on push
    always_ff @(posedge clk) begin
        if (push) mem_q[wr_q] <= din;
    end

    // Move pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (push)   wr_q <= wr_q + 1'b1;
            if (do_pop) rd_q <= rd_q + 1'b1;
            count_q <= count_q + (AW+1)'(push) - (AW+1)'(do_pop);
        end
    end

    // R9
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count_q < (AW+1)'(DEPTH)));
    // R10
    fifo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= (AW+1)'(DEPTH));
    // R8
    fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !pop) |=> (valid && $stable(dout)));
endmodule

// File: rtl/mlp_attack_core.sv
// Top of the classifier: 6-2-2-1 network in two handshaked stages plus a verdict FIFO.
// Assumes parameter writes happen while the pipeline is empty; a full FIFO stalls the input.
module mlp_attack_core
    import mlp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DW-1:0]        cfg_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [N_FEAT*DW-1:0] in_feat,
    output logic                 pred_valid,
    input  logic                 pred_ready,
    output logic                 pred_attack,
    output logic [N_HID*DW-1:0]  tap_h1,
    output logic [N_HID*DW-1:0]  tap_h2,
    output logic [DW-1:0]        tap_out
);
    localparam int FIFO_DEPTH = 16;

    logic [NUM_REGS*DW-1:0] prm;
    logic [N_HID*DW-1:0]    h1_d, h2_d;
    logic [N_HID*DW-1:0]    h1_s1_q, h1_s2_q, h2_s2_q;
    logic                   v1_q, v2_q;
    logic                   r1, r2, fifo_full, push;
    q_t                     out_act;
    logic                   verdict;

    mlp_param_bank u_bank (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_data), .regs_flat(prm)
    );

    // Stage one and two neurons
    for (genvar n = 0; n < N_HID; n++) begin : g_hid
        mlp_neuron #(.N_IN(N_FEAT)) u_l1 (
            .x_flat(in_feat),
            .w_flat(prm[(L1_W_BASE + n*N_FEAT)*DW +: N_FEAT*DW]),
            .bias(q_t'(prm[(L1_B_BASE + n)*DW +: DW])),
            .act(h1_d[n*DW +: DW])
        );
        mlp_neuron #(.N_IN(N_HID)) u_l2 (
            .x_flat(h1_s1_q),
            .w_flat(prm[(L2_W_BASE + n*N_HID)*DW +: N_HID*DW]),
            .bias(q_t'(prm[(L2_B_BASE + n)*DW +: DW])),
            .act(h2_d[n*DW +: DW])
        );
    end

    mlp_neuron #(.N_IN(N_HID)) u_out (
        .x_flat(h2_s2_q),
        .w_flat(prm[OUT_W_BASE*DW +: N_HID*DW]),
        .bias(q_t'(prm[OUT_B*DW +: DW])),
        .act(out_act)
    );

    assign verdict  = (out_act >= q_t'(HALF_Q));
    assign r2       = !v2_q || !fifo_full;
    assign r1       = !v1_q || r2;
    assign in_ready = r1;
    assign push     = v2_q && !fifo_full;

    // Stage one: register first hidden layer activations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q    <= 1'b0;
            h1_s1_q <= '0;
        end else if (r1) begin
            v1_q <= in_valid;
            if (in_valid) h1_s1_q <= h1_d;
        end
    end

    // Stage two: register second hidden layer and carry stage-one values along
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2_q    <= 1'b0;
            h1_s2_q <= '0;
            h2_s2_q <= '0;
        end else if (r2) begin
            v2_q <= v1_q;
            if (v1_q) begin
                h1_s2_q <= h1_s1_q;
                h2_s2_q <= h2_d;
            end
        end
    end

    // Capture per-neuron activations of the record entering the FIFO
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_h1  <= '0;
            tap_h2  <= '0;
            tap_out <= '0;
        end else if (push) begin
            tap_h1  <= h1_s2_q;
            tap_h2  <= h2_s2_q;
            tap_out <= out_act;
        end
    end

    mlp_pred_fifo #(.DEPTH(FIFO_DEPTH), .W(1)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(verdict), .full(fifo_full),
        .pop(pred_ready), .valid(pred_valid), .dout(pred_attack)
    );

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v1_q && !r2) |=> (v1_q && $stable(h1_s1_q)));
    // R4
    tap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(tap_out) >= 0) && ($signed(tap_out) <= ONE_Q));
    // R9
    backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> v1_q);
endmodule

// File: tb/sim_mlp_attack_core.sv
module sim_mlp_attack_core;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [4:0]  cfg_addr;
    logic [15:0] cfg_data;
    logic        in_valid;
    logic        in_ready;
    logic [95:0] in_feat;
    logic        pred_valid;
    logic        pred_ready;
    logic        pred_attack;
    logic [31:0] tap_h1, tap_h2;
    logic [15:0] tap_out;

    always #2 clk = ~clk;

    mlp_attack_core u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_feat(in_feat),
        .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_attack(pred_attack),
        .tap_h1(tap_h1), .tap_h2(tap_h2), .tap_out(tap_out)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;
    int prm [23];
    int feat [6];
    int r_h1 [2], r_h2 [2], r_o, r_lab;
    int exp_q [1024];
    int wr_i = 0, rd_i = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int fold(input longint acc);
        logic signed [31:0] a32;
        int s;
        a32 = acc[31:0];
        s = int'(a32) >>> 8;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    function automatic int sig(input int s);
        if (s < -1024) return 0;
        if (s > 1024) return 256;
        return 128 + (s >>> 3);
    endfunction

    function automatic int sx(input int v);
        return int'($signed(16'(v)));
    endfunction

    task automatic model();
        longint acc;
        for (int n = 0; n < 2; n++) begin
            acc = longint'(sx(prm[12+n])) * 256;
            for (int i = 0; i < 6; i++) acc += longint'(sx(feat[i])) * sx(prm[n*6+i]);
            r_h1[n] = sig(fold(acc));
        end
        for (int n = 0; n < 2; n++) begin
            acc = longint'(sx(prm[18+n])) * 256;
            for (int i = 0; i < 2; i++) acc += longint'(r_h1[i]) * sx(prm[14+n*2+i]);
            r_h2[n] = sig(fold(acc));
        end
        acc = longint'(sx(prm[22])) * 256;
        for (int i = 0; i < 2; i++) acc += longint'(r_h2[i]) * sx(prm[20+i]);
        r_o = sig(fold(acc));
        r_lab = (r_o >= 128) ? 1 : 0;
    endtask

    task automatic put_feat();
        for (int i = 0; i < 6; i++) in_feat[i*16 +: 16] = 16'(feat[i]);
    endtask

    task automatic wr_cfg(input int a, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_data = 16'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_all();
        for (int a = 0; a < 23; a++) wr_cfg(a, prm[a]);
    endtask

    task automatic rnd_prm();
        for (int a = 0; a < 23; a++) prm[a] = int'($urandom_range(1024)) - 512;
    endtask

    // One isolated record: latency, verdict and tap checks (R5 R6 R7 R10)
    task automatic single(input string tag);
        model();
        @(negedge clk);
        put_feat(); in_valid = 1'b1; pred_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R7 not yet k+0"}, int'(pred_valid), 0);
        @(negedge clk);
        chk({tag, " R7 not yet k+1"}, int'(pred_valid), 0);
        @(negedge clk);
        chk({tag, " R7 head after k+2"}, int'(pred_valid), 1);
        chk({tag, " R5 verdict"}, int'(pred_attack), r_lab);
        chk({tag, " R6 h1n0"}, sx(int'(tap_h1[15:0])), r_h1[0]);
        chk({tag, " R6 h1n1"}, sx(int'(tap_h1[31:16])), r_h1[1]);
        chk({tag, " R6 h2n0"}, sx(int'(tap_h2[15:0])), r_h2[0]);
        chk({tag, " R6 h2n1"}, sx(int'(tap_h2[31:16])), r_h2[1]);
        chk({tag, " R4 out"}, sx(int'(tap_out)), r_o);
        pred_ready = 1'b1;
        @(negedge clk);
        pred_ready = 1'b0;
        chk({tag, " R10 empty after pop"}, int'(pred_valid), 0);
    endtask

    // Streaming with random gaps and random consumer (R3 R8)
    task automatic stream(input int n, input int vpct, input int rpct);
        int sent = 0;
        bit pend = 0;
        while (sent < n || rd_i < wr_i) begin
            @(negedge clk);
            if (!pend && sent < n && int'($urandom_range(99)) < vpct) begin
                for (int i = 0; i < 6; i++) feat[i] = int'($urandom_range(4096)) - 2048;
                put_feat();
                pend = 1;
            end
            in_valid = pend;
            pred_ready = (int'($urandom_range(99)) < rpct);
            #1;
            if (pend && in_ready) begin
                model();
                exp_q[wr_i % 1024] = r_lab; wr_i++;
                sent++; pend = 0;
            end
            if (pred_valid && pred_ready) begin
                chk("R8 ordered verdict", int'(pred_attack), exp_q[rd_i % 1024]);
                rd_i++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; pred_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
        in_valid = 1'b0; in_feat = '0; pred_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 pred_valid", int'(pred_valid), 0);
        chk("R1 taps", int'(tap_h1 != 0 || tap_h2 != 0 || tap_out != 0), 0);

        // R1: zero parameters give 0.5 everywhere
        for (int a = 0; a < 23; a++) prm[a] = 0;
        for (int i = 0; i < 6; i++) feat[i] = 300 * i - 700;
        single("R1 zero model");

        // R4: activation boundaries via feature 0 with weights +1.0 / -1.0
        for (int a = 0; a < 23; a++) prm[a] = 0;
        prm[0] = 256; prm[6] = -256;
        load_all();
        for (int i = 0; i < 6; i++) feat[i] = 0;
        feat[0] = 1024;  single("R4 +4.0");
        feat[0] = 1025;  single("R4 above +4");
        feat[0] = -1025; single("R4 below -4");
        feat[0] = 9;     single("R4 slope");

        // R5: threshold exactly at 0.5 and just below
        prm[22] = 0;  load_all(); feat[0] = 0; single("R5 at half");
        prm[22] = -1; load_all(); single("R5 below half");

        // R3: saturation and wrap with extreme values
        rnd_prm();
        prm[0] = 16'h7FFF; prm[1] = 16'h7FFF; prm[7] = 16'h8000;
        load_all();
        for (int i = 0; i < 6; i++) feat[i] = 16'h7FFF;
        single("R3 extremes");

        // R2: out-of-range writes change nothing
        rnd_prm(); load_all();
        for (int i = 0; i < 6; i++) feat[i] = int'($urandom_range(2048)) - 1024;
        wr_cfg(23, 16'h7FFF); wr_cfg(31, 16'h8000);
        single("R2 ignored addr");

        // R3 R8: random streams under two parameter sets
        stream(60, 70, 60);
        rnd_prm(); load_all();
        stream(60, 100, 30);

        // R9: stall consumer, count acceptances, then drain
        begin
            int acc_n = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                for (int i = 0; i < 6; i++) feat[i] = int'($urandom_range(4096)) - 2048;
                put_feat(); in_valid = 1'b1; pred_ready = 1'b0;
                #1;
                if (in_ready) begin
                    model();
                    exp_q[wr_i % 1024] = r_lab; wr_i++;
                    acc_n++;
                end
            end
            @(negedge clk);
            in_valid = 1'b0;
            chk("R9 accepted count", acc_n, 18);
            chk("R9 in_ready low", int'(in_ready), 0);
            stream(0, 0, 100);
            chk("R9 all drained", rd_i, wr_i);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule